// File: doc/BRIEF.md
# Direct-Mapped Byte Cache with Shared Address/Data Bus

A small direct-mapped cache holding sixteen lines of two bytes, each line tagged with two bits. Requests arrive as beats on one 8-bit bus. A beat select decides whether the bus carries an address or a write byte, and a read/write select decides whether the beat starts a lookup. An address beat stores the low seven bits of the bus in an address register. A read beat returns the addressed byte and a hit or miss flag. A write beat stores its bus byte into the line named by the stored address and retags that line. There is no backing memory. A miss is only reported.

An active-low initialise input starts a sweep that fills every data byte with all-ones and every tag with binary 11. The sweep writes one line per clock, so each array has a single write port and can map to RAM. While the sweep runs, the block accepts nothing.

The input beat and the read response each use a valid/ready handshake. The input side is ready only when the sweep is idle and no response is held. A response stays on its outputs until it is taken, and no new beat is accepted while it waits.

Top module: `tiny_dm_cache`

## Requirements
- R1: While `init_n` is low, `busy` is 1 and `in_ready` is 0. After `init_n` rises, `busy` stays high for exactly 16 rising edges (one line per edge), then falls.
- R2: After a sweep, every line reads 8'hFF under tag 2'b11. A read with any other tag misses.
- R3: An address beat (`in_sel_data`=0) stores `in_bus[6:0]` as the current address. `in_bus[7]` has no effect on the address.
- R4: A read beat (`in_rd`=1) produces `rsp_valid` one edge after acceptance. Exactly one of `rsp_hit`/`rsp_miss` is 1 with it. `rsp_data` is the addressed byte on a hit and 8'h00 on a miss.
- R5: Address field positions: bits 6:5 are the tag, bits 4:1 select one of 16 lines, and bit 0 selects the byte (0 = low byte, 1 = high byte). A hit means the stored tag of the selected line equals bits 6:5.
- R6: A data beat with `in_rd`=0 writes `in_bus` into the byte selected by the stored address. The other byte of that line is left unchanged.
- R7: The same write sets the line's tag to bits 6:5 of the stored address, so a read under the line's previous tag then misses.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, the response outputs hold stable and `in_ready` is 0. Beats offered then are ignored, including any address they carry.
- R9: Beats offered while `busy`=1 are ignored. They start no response and write nothing.
- R10: A data beat with `in_rd`=1 re-reads the stored address and writes nothing.
- R11: A later low pulse on `init_n` restores all lines and tags to their swept values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| init_n | input | 1 | Active-low initialise; asynchronously resets the control state and starts the sweep |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat accepted at this edge when also valid |
| in_sel_data | input | 1 | 0: bus is an address, 1: bus is a data byte |
| in_rd | input | 1 | 1: read beat, 0: write/latch beat |
| in_bus | input | 8 | Shared address/data bus |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response taken at this edge when also valid |
| rsp_data | output | 8 | Byte read, zero on miss |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| busy | output | 1 | Initialisation sweep running |

## Verification
On every cycle, the assertions check four properties:
- a held response does not change while it waits;
- every response has exactly one of hit and miss, with zero data on a miss;
- no response begins right after a busy cycle, and the sweep never shares a cycle with a user write;
- the sweep ends only after wrapping through all lines.

Only the bench scenarios can show the stored contents. These include the byte each read returns, the effect of a write on the other byte of its line, retagging, the ignored bus bit, beats dropped under back-pressure or during a sweep, and the restore after re-initialising.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int LANES = 2;
  typedef enum logic {BEAT_ADDR = 1'b0, BEAT_DATA = 1'b1} beat_e;
endpackage

// File: rtl/dmc_init_seq.sv
module dmc_init_seq #(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             init_n,
  output logic             busy,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == IDX_W'(LINES - 1)) busy <= 1'b0;
    end
  end

  assert_sweep_wraps_R1: assert property (@(posedge clk) disable iff (!init_n)
    $fell(busy) |-> ptr == '0);
endmodule

// File: rtl/dmc_store.sv
module dmc_store #(
  parameter int LINES  = 16,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                                    clk,
  input  logic                                    init_n,
  input  logic                                    sweep_we,
  input  logic [IDX_W-1:0]                        sweep_idx,
  input  logic                                    wr_en,
  input  logic [IDX_W-1:0]                        line_idx,
  input  logic                                    byte_off,
  input  logic [TAG_W-1:0]                        wr_tag,
  input  logic [DATA_W-1:0]                       wr_byte,
  output logic [TAG_W-1:0]                        rd_tag,
  output logic [dmc_pkg::LANES-1:0][DATA_W-1:0]   rd_bytes
);
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (sweep_we)   tag_mem[sweep_idx] <= '1;
    else if (wr_en) tag_mem[line_idx]  <= wr_tag;
  end
  assign rd_tag = tag_mem[line_idx];

  for (genvar g = 0; g < dmc_pkg::LANES; g++) begin : g_lane
    logic [DATA_W-1:0] lane_mem [LINES];
    always_ff @(posedge clk) begin
      if (sweep_we)
        lane_mem[sweep_idx] <= '1;
      else if (wr_en && (byte_off == 1'(g)))
        lane_mem[line_idx] <= wr_byte;
    end
    assign rd_bytes[g] = lane_mem[line_idx];
  end

  assert_one_writer_R9: assert property (@(posedge clk) disable iff (!init_n)
    $onehot0({sweep_we, wr_en}));
endmodule

// File: rtl/dmc_resp.sv
module dmc_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic              take,
  input  logic              hit_in,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              rsp_miss
);
  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= hit_in;
      rsp_miss  <= !hit_in;
      rsp_data  <= hit_in ? byte_in : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!init_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));
  assert_hit_xor_miss_R4: assert property (@(posedge clk) disable iff (!init_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!init_n)
    rsp_valid && rsp_miss |-> rsp_data == '0);
endmodule

// File: rtl/tiny_dm_cache.sv
module tiny_dm_cache #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - 1 - IDX_W
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sel_data,
  input  logic              in_rd,
  input  logic [DATA_W-1:0] in_bus,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              busy
);
  import dmc_pkg::*;

  logic [IDX_W-1:0]            sweep_ptr;
  logic [ADDR_W-1:0]           addr_q, look_addr;
  logic                        accept, is_data, rd_take, wr_en;
  logic [TAG_W-1:0]            stored_tag;
  logic [LANES-1:0][DATA_W-1:0] line_bytes;

  dmc_init_seq #(.LINES(LINES)) u_seq (
    .clk(clk), .init_n(init_n), .busy(busy), .ptr(sweep_ptr)
  );

  assign in_ready = !busy && (!rsp_valid || rsp_ready);
  assign accept   = in_valid && in_ready;
  assign is_data  = (beat_e'(in_sel_data) == BEAT_DATA);

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)                addr_q <= '0;
    else if (accept && !is_data) addr_q <= in_bus[ADDR_W-1:0];
  end

  assign look_addr = is_data ? addr_q : in_bus[ADDR_W-1:0];
  assign rd_take   = accept && in_rd;
  assign wr_en     = accept && is_data && !in_rd;

  dmc_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .init_n(init_n),
    .sweep_we(busy), .sweep_idx(sweep_ptr),
    .wr_en(wr_en), .line_idx(look_addr[IDX_W:1]), .byte_off(look_addr[0]),
    .wr_tag(look_addr[ADDR_W-1:IDX_W+1]), .wr_byte(in_bus),
    .rd_tag(stored_tag), .rd_bytes(line_bytes)
  );

  dmc_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .init_n(init_n), .take(rd_take),
    .hit_in(stored_tag == look_addr[ADDR_W-1:IDX_W+1]),
    .byte_in(line_bytes[look_addr[0]]),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss)
  );

  assert_no_rsp_after_busy_R9: assert property (@(posedge clk) disable iff (!init_n)
    $rose(rsp_valid) |-> !$past(busy));
endmodule

// File: tb/sim_tiny_dm_cache.sv
module sim_tiny_dm_cache;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic init_n, in_valid, in_ready, in_sel_data, in_rd, rsp_valid, rsp_ready;
  logic rsp_hit, rsp_miss, busy;
  logic [7:0] in_bus, rsp_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny_dm_cache u0 (
    .clk(clk), .init_n(init_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel_data(in_sel_data), .in_rd(in_rd), .in_bus(in_bus),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; one edge later, returns at the following negedge
  task automatic beat(input logic sel, input logic rd, input logic [7:0] bus);
    in_valid = 1'b1; in_sel_data = sel; in_rd = rd; in_bus = bus;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic read_chk(input logic [6:0] a, input logic hit, input logic [7:0] d, input string req);
    beat(1'b0, 1'b1, {1'b0, a});
    check({req, " rsp_valid"}, rsp_valid, 1);
    check({req, " hit"}, rsp_hit, hit);
    check({req, " miss"}, rsp_miss, !hit);
    check({req, " data"}, rsp_data, d);
  endtask

  task automatic write_byte(input logic [7:0] abus, input logic [7:0] d);
    beat(1'b0, 1'b0, abus);
    beat(1'b1, 1'b0, d);
  endtask

  task automatic wait_sweep(output int n);
    n = 0;
    while (busy && n < 100) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 busy in init", busy, 1);
    check("R1 in_ready in init", in_ready, 0);
    check("R1 rsp_valid in init", rsp_valid, 0);
  endtask

  task automatic t_sweep();
    int n;
    init_n = 1'b1;
    wait_sweep(n);
    check("R1 sweep length", n, 16);
    check("R1 ready after sweep", in_ready, 1);
  endtask

  task automatic t_post_init();
    read_chk(7'b11_0000_0, 1'b1, 8'hFF, "R2 line0 lo");
    read_chk(7'b11_1010_1, 1'b1, 8'hFF, "R2 line10 hi");
    read_chk(7'b00_0011_0, 1'b0, 8'h00, "R2 R4 tag00 miss");
    read_chk(7'b01_1111_1, 1'b0, 8'h00, "R2 tag01 miss");
  endtask

  task automatic t_write();
    write_byte({1'b1, 7'b01_0011_0}, 8'hA5);  // R3: bus bit 7 set
    read_chk(7'b01_0011_0, 1'b1, 8'hA5, "R6 R3 written byte");
    read_chk(7'b01_0011_1, 1'b1, 8'hFF, "R6 other byte kept");
    read_chk(7'b11_0011_0, 1'b0, 8'h00, "R7 old tag misses");
  endtask

  task automatic t_reread();
    read_chk(7'b01_0011_0, 1'b1, 8'hA5, "R10 prime");
    beat(1'b1, 1'b1, 8'h77);
    check("R10 reread valid", rsp_valid, 1);
    check("R10 reread data", rsp_data, 8'hA5);
    read_chk(7'b01_0011_0, 1'b1, 8'hA5, "R10 no write on rd data beat");
  endtask

  task automatic t_backpressure();
    rsp_ready = 1'b0;
    beat(1'b0, 1'b1, {1'b0, 7'b01_0011_0});
    check("R8 held valid", rsp_valid, 1);
    check("R8 in_ready low", in_ready, 0);
    in_valid = 1'b1; in_sel_data = 1'b0; in_rd = 1'b1; in_bus = {1'b0, 7'b00_1111_0};
    repeat (2) begin
      @(posedge clk); @(negedge clk);
      check("R8 still valid", rsp_valid, 1);
      check("R8 data stable", rsp_data, 8'hA5);
      check("R8 hit stable", rsp_hit, 1);
    end
    in_valid = 1'b0; rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 drained", rsp_valid, 0);
    beat(1'b1, 1'b1, 8'h00);
    check("R8 dropped address", rsp_data, 8'hA5);
    check("R8 dropped address hit", rsp_hit, 1);
  endtask

  task automatic t_fields();
    write_byte({1'b0, 7'b10_1111_1}, 8'h3C);
    read_chk(7'b10_1111_1, 1'b1, 8'h3C, "R5 hi byte");
    read_chk(7'b10_1111_0, 1'b1, 8'hFF, "R5 lo byte");
    read_chk(7'b10_1110_1, 1'b0, 8'h00, "R5 neighbour line");
    read_chk(7'b11_1111_1, 1'b0, 8'h00, "R5 tag mismatch");
  endtask

  task automatic t_reinit();
    int n;
    init_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 busy on reinit", busy, 1);
    init_n = 1'b1;
    write_byte({1'b0, 7'b00_0101_0}, 8'h12);
    beat(1'b0, 1'b1, {1'b0, 7'b11_0000_0});
    check("R9 no rsp while busy", rsp_valid, 0);
    check("R9 not ready while busy", in_ready, 0);
    wait_sweep(n);
    read_chk(7'b00_0101_0, 1'b0, 8'h00, "R9 busy write dropped");
    read_chk(7'b11_0101_0, 1'b1, 8'hFF, "R9 line intact");
    read_chk(7'b10_1111_1, 1'b0, 8'h00, "R11 tag restored");
    read_chk(7'b11_1111_1, 1'b1, 8'hFF, "R11 data restored");
    read_chk(7'b11_0011_0, 1'b1, 8'hFF, "R11 line3 restored");
  endtask

  initial begin
    init_n = 1'b0; in_valid = 1'b0; in_sel_data = 1'b0; in_rd = 1'b0;
    in_bus = 8'h00; rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sweep();
    t_post_init();
    t_write();
    t_reread();
    t_backpressure();
    t_fields();
    t_reinit();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule